// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog timer with a small register-bus slave. A free-running up-counter starts from a programmable load value. When it wraps past all-ones, the block raises a one-cycle reset request, latches an overflow event and reloads itself. Software keeps the system alive by writing a new value into the kick register. The counter can be stopped or started only through an exact two-word key handshake written to one command register. A stray write therefore cannot switch the watchdog off.

Registers that sit in the slow counting domain are updated through a fixed-latency pending stage. While a register's pending flag is set, further writes to it are dropped. Software polls a pending-status word before it issues the next write. A prescaler slows the count by a power of two. A delay-compare value raises a second event. A self-clearing soft-reset control returns everything to the power-up state.

Word addresses used by software: 0 control (bit 0 soft reset, bit 1 running, read only), 1 prescaler (bit 0 enable, bits 3:1 exponent), 2 counter, 3 load, 4 kick, 5 key command (bits 15:0), 6 delay compare, 7 pending status (bit index = synchronised register address minus one), 8 event status (bit 0 overflow, bit 1 delay; write 1 to clear), 9 event enable (write 1 to set), 10 event enable (write 1 to clear).

Top module: `wdt_keyed_timer`

## Requirements
- R1: After reset the timer runs, the load, counter, event enable and event status read 0, the prescaler reads 1 (enabled, exponent 0), the pending status reads 0, and rst_req_o and irq_o are low.
- R2: Committing 0xAAAA and then 0x5555 to the key command register, with no other key write between them, stops the counter (control bit 1 reads 0).
- R3: Committing 0xBBBB and then 0x4444 to the key command register, with no other key write between them, starts the counter (control bit 1 reads 1).
- R4: Any other key write leaves the run state unchanged and restarts the check. This includes a wrong second word, or a second word with no first word before it.
- R5: A write to a synchronised register (addresses 1 to 6) sets its pending bit. The new value takes effect and the bit clears PEND_CYC cycles later. A write to that register while its bit is set is dropped.
- R6: A kick write whose value differs from the previous kick value reloads the counter from the load register. A kick with an unchanged value does nothing.
- R7: The counter advances once every 2^exponent cycles when the prescaler is enabled, and once every cycle when it is disabled.
- R8: When the counter passes 0xFFFFFFFF while running, rst_req_o pulses for one cycle, event status bit 0 sets and the counter reloads from the load register.
- R9: When the running counter steps onto the delay-compare value, event status bit 1 sets.
- R10: Writing 1 to an event status bit clears it. irq_o is high while any status bit has its enable set. The enable set and clear addresses set or clear individual bits.
- R11: Writing 1 to control bit 0 starts a soft reset. That bit reads 1 for SRST_CYC cycles and then clears, and the block returns to the R1 state.
- R12: While stopped, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Counting and bus clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | DATA_W | Write data |
| we_i | input | 1 | Write strobe, one write per cycle |
| rdata_o | output | DATA_W | Read data for addr_i (combinational) |
| irq_o | output | 1 | Enabled event pending |
| rst_req_o | output | 1 | One-cycle reset request on overflow |

## Verification
A wrong key state shows up one pending latency after the second key word: control bit 1 reads the wrong value, or the counter stays frozen or keeps moving. A wrong prescaler phase or a missed reload shows in the counter value read back. The counter is sampled over a known window, so the error is visible within one prescaler period. Pending faults are visible in the very next read of the pending word. Overflow faults appear as a missing or extra rst_req_o pulse, or a wrong status bit, within one wrap period of the counter.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // key command state
   typedef enum logic [1:0] {
      KS_IDLE   = 2'd0,
      KS_STOP1  = 2'd1,
      KS_START1 = 2'd2
   } key_st_e;

   localparam int KEY_W = 16;
   localparam logic [KEY_W-1:0] KEY_STOP_A  = 16'hAAAA;
   localparam logic [KEY_W-1:0] KEY_STOP_B  = 16'h5555;
   localparam logic [KEY_W-1:0] KEY_START_A = 16'hBBBB;
   localparam logic [KEY_W-1:0] KEY_START_B = 16'h4444;

   // synchronised register slots; word address = slot + 1
   localparam int SL_PRESC = 0;
   localparam int SL_COUNT = 1;
   localparam int SL_LOAD  = 2;
   localparam int SL_KICK  = 3;
   localparam int SL_KEYS  = 4;
   localparam int SL_DELAY = 5;
   localparam int NSYNC    = 6;

   localparam int A_CTRL  = 0;
   localparam int A_PEND  = 7;
   localparam int A_STAT  = 8;
   localparam int A_ENSET = 9;
   localparam int A_ENCLR = 10;

   localparam int EV_OVF = 0;
   localparam int EV_DLY = 1;
   localparam int NEV    = 2;

endpackage

// File: rtl/wdt_sync_slot.sv
module wdt_sync_slot #(
   parameter int W        = 32,
   parameter int PEND_CYC = 4
) (
   input  logic         clk_i,
   input  logic         clr_i,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic         pend_o,
   output logic         commit_o,
   output logic [W-1:0] data_o
);
   localparam int CW = (PEND_CYC < 2) ? 1 : $clog2(PEND_CYC);

   logic          pend_q;
   logic [CW-1:0] cnt_q;
   logic [W-1:0]  data_q;

   always_ff @(posedge clk_i) begin
      if (clr_i) begin
         pend_q <= 1'b0;
         cnt_q  <= '0;
         data_q <= '0;
      end else if (!pend_q) begin
         if (wr_i) begin
            pend_q <= 1'b1;
            cnt_q  <= CW'(PEND_CYC - 1);
            data_q <= wdata_i;
         end
      end else if (cnt_q == '0) begin
         pend_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign pend_o   = pend_q;
   assign commit_o = pend_q && (cnt_q == '0);
   assign data_o   = data_q;

   // R5: a write arriving while busy is dropped
   p_busy_drop_r5 : assert property (@(posedge clk_i) disable iff (clr_i)
      (pend_q && wr_i) |=> $stable(data_q));

   // R5: the flag clears in the cycle after the commit
   p_commit_clears_r5 : assert property (@(posedge clk_i) disable iff (clr_i)
      commit_o |=> !pend_q);

endmodule

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm
   import wdt_pkg::*;
(
   input  logic             clk_i,
   input  logic             clr_i,
   input  logic             commit_i,
   input  logic [KEY_W-1:0] key_i,
   output logic             running_o
);
   key_st_e st_q;
   logic    run_q;

   always_ff @(posedge clk_i) begin
      if (clr_i) begin
         st_q  <= KS_IDLE;
         run_q <= 1'b1;
      end else if (commit_i) begin
         if (st_q == KS_STOP1 && key_i == KEY_STOP_B) begin
            run_q <= 1'b0;
            st_q  <= KS_IDLE;
         end else if (st_q == KS_START1 && key_i == KEY_START_B) begin
            run_q <= 1'b1;
            st_q  <= KS_IDLE;
         end else if (key_i == KEY_STOP_A) begin
            st_q <= KS_STOP1;
         end else if (key_i == KEY_START_A) begin
            st_q <= KS_START1;
         end else begin
            st_q <= KS_IDLE;
         end
      end
   end

   assign running_o = run_q;

   p_stop_key_r2 : assert property (@(posedge clk_i) disable iff (clr_i)
      $fell(run_q) |-> $past(commit_i && key_i == KEY_STOP_B));

   p_start_key_r3 : assert property (@(posedge clk_i) disable iff (clr_i)
      $rose(run_q) |-> $past(commit_i && key_i == KEY_START_B));

   p_no_idle_change_r4 : assert property (@(posedge clk_i) disable iff (clr_i)
      !commit_i |=> $stable(run_q));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int CNT_W     = 32,
   parameter int PTV_W     = 3,
   parameter bit HAS_PRESC = 1'b1
) (
   input  logic             clk_i,
   input  logic             clr_i,
   input  logic             run_i,
   input  logic             presc_en_i,
   input  logic [PTV_W-1:0] ptv_i,
   input  logic [CNT_W-1:0] load_i,
   input  logic [CNT_W-1:0] delay_i,
   input  logic             cnt_wr_i,
   input  logic [CNT_W-1:0] cnt_wdata_i,
   input  logic             reload_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o,
   output logic             dly_o
);
   localparam int DIV_W = (1 << PTV_W) - 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic             ovf_q;
   logic             dly_q;
   logic             tick;

   generate
      if (HAS_PRESC) begin : g_presc
         logic [DIV_W-1:0] div_q;
         logic [DIV_W-1:0] mask;
         always_comb mask = ~({DIV_W{1'b1}} << ptv_i);
         always_ff @(posedge clk_i) begin
            if (clr_i || reload_i || cnt_wr_i || !run_i) div_q <= '0;
            else                                         div_q <= div_q + 1'b1;
         end
         assign tick = !presc_en_i || ((div_q & mask) == mask);
      end else begin : g_nopresc
         logic unused_presc;
         assign unused_presc = presc_en_i ^ (^ptv_i);
         assign tick = 1'b1;
      end
   endgenerate

   assign cnt_inc = cnt_q + 1'b1;

   always_ff @(posedge clk_i) begin
      if (clr_i) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
         dly_q <= 1'b0;
      end else begin
         ovf_q <= 1'b0;
         dly_q <= 1'b0;
         if (cnt_wr_i) begin
            cnt_q <= cnt_wdata_i;
         end else if (reload_i) begin
            cnt_q <= load_i;
         end else if (run_i && tick) begin
            if (&cnt_q) begin
               cnt_q <= load_i;
               ovf_q <= 1'b1;
            end else begin
               cnt_q <= cnt_inc;
               dly_q <= (cnt_inc == delay_i);
            end
         end
      end
   end

   assign cnt_o = cnt_q;
   assign ovf_o = ovf_q;
   assign dly_o = dly_q;

   p_ovf_reload_r8 : assert property (@(posedge clk_i) disable iff (clr_i)
      ovf_q |-> (cnt_q == $past(load_i)));

   p_ovf_from_top_r8 : assert property (@(posedge clk_i) disable iff (clr_i)
      ovf_q |-> $past(&cnt_q));

   p_stopped_hold_r12 : assert property (@(posedge clk_i) disable iff (clr_i)
      (!run_i && !cnt_wr_i && !reload_i) |=> $stable(cnt_q));

endmodule

// File: rtl/wdt_keyed_timer.sv
module wdt_keyed_timer
   import wdt_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4,
   parameter int PTV_W     = 3,
   parameter int PEND_CYC  = 4,
   parameter int SRST_CYC  = 4,
   parameter bit HAS_PRESC = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              we_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o,
   output logic              rst_req_o
);
   localparam int SRW = $clog2(SRST_CYC + 1);

   generate
      if (DATA_W < KEY_W) begin : g_bad_width
         initial $error("DATA_W must hold a key word");
      end
      if (PTV_W < 1 || PTV_W > 4) begin : g_bad_ptv
         initial $error("PTV_W out of range");
      end
      if (PEND_CYC < 1 || SRST_CYC < 1) begin : g_bad_lat
         initial $error("latencies must be at least one cycle");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         initial $error("ADDR_W too small for the map");
      end
   endgenerate

   // soft reset sequencer
   logic [SRW-1:0] srst_q;
   logic           srst_act;
   logic           clr;

   assign srst_act = (srst_q != '0);
   assign clr      = !rst_ni || srst_act;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         srst_q <= '0;
      end else if (srst_act) begin
         srst_q <= srst_q - 1'b1;
      end else if (we_i && addr_i == ADDR_W'(A_CTRL) && wdata_i[0]) begin
         srst_q <= SRW'(SRST_CYC);
      end
   end

   // synchronised register slots
   logic [NSYNC-1:0]  sl_wr;
   logic [NSYNC-1:0]  sl_pend;
   logic [NSYNC-1:0]  sl_commit;
   logic [DATA_W-1:0] sl_data [NSYNC];

   generate
      for (genvar i = 0; i < NSYNC; i++) begin : g_slot
         assign sl_wr[i] = we_i && (addr_i == ADDR_W'(i + 1));
         wdt_sync_slot #(.W(DATA_W), .PEND_CYC(PEND_CYC)) u_slot (
            .clk_i    (clk_i),
            .clr_i    (clr),
            .wr_i     (sl_wr[i]),
            .wdata_i  (wdata_i),
            .pend_o   (sl_pend[i]),
            .commit_o (sl_commit[i]),
            .data_o   (sl_data[i])
         );
      end
   endgenerate

   // applied registers
   logic              presc_en_q;
   logic [PTV_W-1:0]  ptv_q;
   logic [DATA_W-1:0] load_q;
   logic [DATA_W-1:0] kick_q;
   logic [DATA_W-1:0] delay_q;
   logic              reload;

   assign reload = sl_commit[SL_KICK] && (sl_data[SL_KICK] != kick_q);

   always_ff @(posedge clk_i) begin
      if (clr) begin
         presc_en_q <= 1'b1;
         ptv_q      <= '0;
         load_q     <= '0;
         kick_q     <= '0;
         delay_q    <= '0;
      end else begin
         if (sl_commit[SL_PRESC]) begin
            presc_en_q <= sl_data[SL_PRESC][0];
            ptv_q      <= sl_data[SL_PRESC][PTV_W:1];
         end
         if (sl_commit[SL_LOAD])  load_q  <= sl_data[SL_LOAD];
         if (sl_commit[SL_KICK])  kick_q  <= sl_data[SL_KICK];
         if (sl_commit[SL_DELAY]) delay_q <= sl_data[SL_DELAY];
      end
   end

   // run control
   logic running;

   wdt_key_fsm u_keys (
      .clk_i     (clk_i),
      .clr_i     (clr),
      .commit_i  (sl_commit[SL_KEYS]),
      .key_i     (sl_data[SL_KEYS][KEY_W-1:0]),
      .running_o (running)
   );

   // counter
   logic [DATA_W-1:0] cnt;
   logic              ovf;
   logic              dly;

   wdt_counter #(.CNT_W(DATA_W), .PTV_W(PTV_W), .HAS_PRESC(HAS_PRESC)) u_cnt (
      .clk_i       (clk_i),
      .clr_i       (clr),
      .run_i       (running),
      .presc_en_i  (presc_en_q),
      .ptv_i       (ptv_q),
      .load_i      (load_q),
      .delay_i     (delay_q),
      .cnt_wr_i    (sl_commit[SL_COUNT]),
      .cnt_wdata_i (sl_data[SL_COUNT]),
      .reload_i    (reload),
      .cnt_o       (cnt),
      .ovf_o       (ovf),
      .dly_o       (dly)
   );

   // events
   logic [NEV-1:0] ev_set;
   logic [NEV-1:0] stat_q;
   logic [NEV-1:0] en_q;
   logic           stat_wr;

   assign ev_set  = {dly, ovf};
   assign stat_wr = we_i && addr_i == ADDR_W'(A_STAT);

   always_ff @(posedge clk_i) begin
      if (clr) begin
         stat_q <= '0;
         en_q   <= '0;
      end else begin
         stat_q <= (stat_q & ~(stat_wr ? wdata_i[NEV-1:0] : '0)) | ev_set;
         if (we_i && addr_i == ADDR_W'(A_ENSET)) en_q <= en_q | wdata_i[NEV-1:0];
         else if (we_i && addr_i == ADDR_W'(A_ENCLR)) en_q <= en_q & ~wdata_i[NEV-1:0];
      end
   end

   assign irq_o     = |(stat_q & en_q);
   assign rst_req_o = ovf;

   // read mux
   always_comb begin
      rdata_o = '0;
      case (addr_i)
         ADDR_W'(A_CTRL):           rdata_o[1:0] = {running, srst_act};
         ADDR_W'(SL_PRESC + 1):     rdata_o[PTV_W:0] = {ptv_q, presc_en_q};
         ADDR_W'(SL_COUNT + 1):     rdata_o = cnt;
         ADDR_W'(SL_LOAD + 1):      rdata_o = load_q;
         ADDR_W'(SL_KICK + 1):      rdata_o = kick_q;
         ADDR_W'(SL_KEYS + 1):      rdata_o[KEY_W-1:0] = sl_data[SL_KEYS][KEY_W-1:0];
         ADDR_W'(SL_DELAY + 1):     rdata_o = delay_q;
         ADDR_W'(A_PEND):           rdata_o[NSYNC-1:0] = sl_pend;
         ADDR_W'(A_STAT):           rdata_o[NEV-1:0] = stat_q;
         ADDR_W'(A_ENSET),
         ADDR_W'(A_ENCLR):          rdata_o[NEV-1:0] = en_q;
         default:                   rdata_o = '0;
      endcase
   end

   p_rst_req_status_r8 : assert property (@(posedge clk_i) disable iff (clr)
      rst_req_o |=> stat_q[EV_OVF]);

   p_w1c_ovf_r10 : assert property (@(posedge clk_i) disable iff (clr)
      (stat_wr && wdata_i[EV_OVF] && !ovf) |=> !stat_q[EV_OVF]);

   p_srst_restores_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      srst_act |=> (load_q == '0 && en_q == '0 && running));

endmodule

// File: tb/tb_wdt_keyed_timer.sv
module tb_wdt_keyed_timer;
   localparam int DW = 32;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          we = 1'b0;
   logic [DW-1:0] rdata;
   logic          irq;
   logic          rst_req;

   always #2 clk = ~clk;

   wdt_keyed_timer dut (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .addr_i    (addr),
      .wdata_i   (wdata),
      .we_i      (we),
      .rdata_o   (rdata),
      .irq_o     (irq),
      .rst_req_o (rst_req)
   );

   int n_chk = 0;
   int n_fail = 0;
   int rr_cnt = 0;

   always @(negedge clk) if (rst_req) rr_cnt++;

   typedef struct {
      logic [AW-1:0] a;
      logic [DW-1:0] exp;
      logic [DW-1:0] msk;
      string         tag;
   } item_t;

   item_t q[$];
   event  sample_ev;

   // monitor: pops expected reads and compares
   initial begin
      forever begin
         @(sample_ev);
         if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_chk++;
            if ((rdata & it.msk) !== (it.exp & it.msk)) begin
               n_fail++;
               $display("FAIL %s: addr %0d actual %h expected %h", it.tag, it.a,
                        rdata & it.msk, it.exp & it.msk);
            end
         end
      end
   end

   task automatic wr(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      addr = AW'(a); wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd_exp(input int a, input logic [DW-1:0] e, input logic [DW-1:0] m,
                         input string t);
      item_t it;
      it.a = AW'(a); it.exp = e; it.msk = m; it.tag = t;
      q.push_back(it);
      @(negedge clk);
      addr = AW'(a);
      #1;
      -> sample_ev;
   endtask

   task automatic rd_val(input int a, output logic [DW-1:0] v);
      @(negedge clk);
      addr = AW'(a);
      #1;
      v = rdata;
   endtask

   task automatic chk(input string t, input logic [DW-1:0] got, input logic [DW-1:0] e);
      n_chk++;
      if (got !== e) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", t, got, e);
      end
   endtask

   task automatic wait_idle();
      logic [DW-1:0] v;
      for (int i = 0; i < 40; i++) begin
         rd_val(7, v);
         if (v == '0) break;
      end
   endtask

   task automatic wr_sync(input int a, input logic [DW-1:0] d);
      wr(a, d);
      wait_idle();
   endtask

   task automatic keys(input logic [DW-1:0] k1, input logic [DW-1:0] k2);
      wr_sync(5, k1);
      wr_sync(5, k2);
   endtask

   task automatic rate(input int exp_delta, input string t);
      logic [DW-1:0] c0;
      logic [DW-1:0] c1;
      rd_val(2, c0);
      repeat (63) @(negedge clk);
      rd_val(2, c1);
      chk(t, c1 - c0, DW'(exp_delta));
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
   end

   initial begin
      int rr0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_exp(0, 32'h2, 32'h3, "R1 ctrl running");
      rd_exp(3, 32'h0, '1, "R1 load");
      rd_exp(1, 32'h1, 32'hF, "R1 prescaler");
      rd_exp(7, 32'h0, '1, "R1 pending");
      rd_exp(9, 32'h0, '1, "R1 irq enable");
      rd_exp(8, 32'h0, '1, "R1 status");
      chk("R1 rst_req low", {31'b0, rst_req}, 32'h0);
      chk("R1 irq low", {31'b0, irq}, 32'h0);

      // R7 prescaler rates
      rate(64, "R7 default rate");
      wr_sync(1, 32'h5);
      rate(16, "R7 exponent 2 rate");
      wr_sync(1, 32'hE);
      rate(64, "R7 disabled prescaler rate");
      wr_sync(1, 32'h1);

      // R5 pending and dropped write
      wr(3, 32'h100);
      wr(3, 32'h200);
      rd_exp(7, 32'h4, '1, "R5 pending bit set");
      wait_idle();
      rd_exp(3, 32'h100, '1, "R5 busy write dropped");

      // R4 broken pair while running
      keys(32'hAAAA, 32'h1234);
      wr_sync(5, 32'h5555);
      rd_exp(0, 32'h2, 32'h2, "R4 wrong stop word ignored");

      // R2 stop
      keys(32'hAAAA, 32'h5555);
      rd_exp(0, 32'h0, 32'h2, "R2 stopped");

      // R4 broken pairs while stopped
      keys(32'hBBBB, 32'h5555);
      rd_exp(0, 32'h0, 32'h2, "R4 mixed pair ignored");
      wr_sync(5, 32'h4444);
      rd_exp(0, 32'h0, 32'h2, "R4 lone second word ignored");

      // R3 start, then stop again
      keys(32'hBBBB, 32'h4444);
      rd_exp(0, 32'h2, 32'h2, "R3 started");
      keys(32'hAAAA, 32'h5555);

      // R6 kick reload
      wr_sync(3, 32'hFFFF_FFF0);
      wr_sync(4, 32'h1);
      rd_exp(2, 32'hFFFF_FFF0, '1, "R6 kick reload");
      repeat (20) @(negedge clk);
      rd_exp(2, 32'hFFFF_FFF0, '1, "R12 stopped counter holds");
      wr_sync(2, 32'h5);
      wr_sync(4, 32'h1);
      rd_exp(2, 32'h5, '1, "R6 unchanged kick ignored");
      wr_sync(4, 32'h2);

      // R8 R9 overflow and delay events
      wr_sync(6, 32'hFFFF_FFF4);
      wr(9, 32'h3);
      rd_exp(9, 32'h3, '1, "R10 enable set");
      rr0 = rr_cnt;
      keys(32'hBBBB, 32'h4444);
      repeat (20) @(negedge clk);
      chk("R8 one reset request", rr_cnt - rr0, 32'h1);
      rd_exp(8, 32'h3, '1, "R8 R9 status bits");
      chk("R10 irq high", {31'b0, irq}, 32'h1);
      keys(32'hAAAA, 32'h5555);
      wr(8, 32'h3);
      rd_exp(8, 32'h0, '1, "R10 write one clears");
      chk("R10 irq low after clear", {31'b0, irq}, 32'h0);
      wr(10, 32'h1);
      rd_exp(9, 32'h2, '1, "R10 enable clear");

      // R11 soft reset
      wr(0, 32'h1);
      rd_exp(0, 32'h1, 32'h1, "R11 soft reset in progress");
      repeat (8) @(negedge clk);
      rd_exp(0, 32'h2, 32'h3, "R11 soft reset done");
      rd_exp(3, 32'h0, '1, "R11 load cleared");
      rd_exp(9, 32'h0, '1, "R11 enable cleared");
      rd_exp(1, 32'h1, 32'hF, "R11 prescaler default");

      repeat (2) @(negedge clk);
      summary();
   end

endmodule